// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block watches eight external pins and turns their activity into interrupt requests for a processor. Each pin is given its own trigger rule: a low level, a falling edge, a rising edge or any change. Edge events are caught in a per-pin flag that stays set until software clears it. Level events produce a request only while the pin is actually low and leave no record behind. A per-pin mask and one global enable decide which events reach the request outputs.

The pins are sampled through a two-flop synchroniser, so the detection works on whatever value the pad carries. This includes a pin that the chip drives itself, which gives software a way to raise an interrupt. A small register interface sets the trigger rules and the mask, reads back the flags and clears them.

The block can also wake the chip from power-down. A strobe marks each sample of a slow wake clock. A pin that is enabled, in level mode and low on two consecutive samples asserts the wake output. Requests stay blocked until the start-up timer reports completion. If the level is gone by then, the chip still wakes but no request is raised.

Top module: `eic_ctrl`

## Requirements
- R1: After reset, both sense registers, the mask and the flags read 0, `irq_req`, `irq_any` and `wake` are 0, and every pin is therefore in low-level mode.
- R2: Register address 0 holds the sense fields of pins 3..0 and address 1 those of pins 7..4. Pin n uses bits [2k+1:2k] of its register, where k = n mod 4. Address 2 is the mask, with bit n for pin n, and address 3 is the flag register. A read with `rd_en` puts the value on `rdata` at the next clock edge, and `rdata` holds it afterwards.
- R3: The sense code 01 sets flag n on any change of the synchronised pin, 10 sets it on a falling edge and 11 on a rising edge. An edge of the other direction leaves the flag unchanged.
- R4: With sense code 00, request n is high while the synchronised pin is low and drops when the pin goes high. No flag bit is set.
- R5: Request n can be high only when `gie` and mask bit n were both 1 at the previous clock edge.
- R6: Writing address 3 clears every flag whose `wdata` bit is 1. Flags whose `wdata` bit is 0 keep their value.
- R7: An edge flag is set even while its mask bit is 0, and it stays set. Setting the mask bit later raises the request.
- R8: While `pwr_down` is 1, a pin that is enabled (mask and `gie`), in sense mode 00 and low at two consecutive `wake_tick` strobes sets `wake`. `wake` stays 1 until `pwr_down` returns to 0, and one cycle later it is 0.
- R9: A `wake_tick` that finds the qualifying pin high restarts the two-sample count, so samples that are not consecutive do not wake.
- R10: While `pwr_down` is 1 and `startup_done` is 0, all requests are 0. A level that is gone before `startup_done` rises leaves `wake` at 1 and produces no request, and a level still held then does produce one.
- R11: `irq_any` is 1 exactly when any bit of `irq_req` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| pin_in | input | 8 | External pin values (asynchronous) |
| gie | input | 1 | Global interrupt enable |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, registered |
| pwr_down | input | 1 | Chip is in power-down |
| startup_done | input | 1 | Start-up timer has expired |
| wake_tick | input | 1 | One-cycle strobe per wake-clock sample |
| irq_req | output | 8 | Per-pin interrupt request, registered |
| irq_any | output | 1 | OR of all requests, registered |
| wake | output | 1 | Wake from power-down |

## Verification
The bench builds the block with its default parameters: eight pins, two synchroniser stages and two wake samples. With these values every sense code can be placed on a different pin in one run, so the modes act side by side and can be told apart. The two-sample wake count is short enough to reach both a qualifying wake and a broken sequence of samples. Both outcomes at the end of start-up can be reached as well: the level gone, which gives a wake without a request, and the level still held, which gives a request.

// File: rtl/eic_pkg.sv
package eic_pkg;
  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } sense_e;

  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] ADDR_SENSE_LO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SENSE_HI = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_MASK     = 2'd2;
  localparam logic [ADDR_W-1:0] ADDR_FLAG     = 2'd3;
endpackage

// File: rtl/eic_sync.sv
module eic_sync #(
  parameter int   W       = 8,
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < STAGES; k++) stage_q[k] <= {W{RST_VAL}};
    end else begin
      stage_q[0] <= d;
      for (int k = 1; k < STAGES; k++) stage_q[k] <= stage_q[k-1];
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/eic_regs.sv
module eic_regs
  import eic_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [NUM_PINS-1:0]   wdata,
  input  logic [NUM_PINS-1:0]   flags,
  output logic [2*NUM_PINS-1:0] sense,
  output logic [NUM_PINS-1:0]   mask,
  output logic [NUM_PINS-1:0]   flag_clr,
  output logic [NUM_PINS-1:0]   rdata
);
  logic [NUM_PINS-1:0] sense_lo_q, sense_hi_q, mask_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sense_lo_q <= '0;
      sense_hi_q <= '0;
      mask_q     <= '0;
    end else if (wr_en) begin
      case (addr)
        ADDR_SENSE_LO: sense_lo_q <= wdata;
        ADDR_SENSE_HI: sense_hi_q <= wdata;
        ADDR_MASK:     mask_q     <= wdata;
        default:       ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_en) begin
      case (addr)
        ADDR_SENSE_LO: rdata <= sense_lo_q;
        ADDR_SENSE_HI: rdata <= sense_hi_q;
        ADDR_MASK:     rdata <= mask_q;
        default:       rdata <= flags;
      endcase
    end
  end

  assign flag_clr = (wr_en && addr == ADDR_FLAG) ? wdata : '0;
  assign sense    = {sense_hi_q, sense_lo_q};
  assign mask     = mask_q;
endmodule

// File: rtl/eic_pin.sv
module eic_pin
  import eic_pkg::*;
#(
  parameter int WAKE_SAMPLES = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   pin_s,
  input  sense_e mode,
  input  logic   enabled,
  input  logic   flag_clr,
  input  logic   pwr_down,
  input  logic   wake_tick,
  output logic   flag,
  output logic   level_low,
  output logic   wake_hit
);
  localparam int CW = $clog2(WAKE_SAMPLES + 1);
  localparam logic [CW-1:0] LAST = CW'(WAKE_SAMPLES - 1);

  logic          prev_q;
  logic          edge_hit;
  logic          qual;
  logic [CW-1:0] cnt_q;

  always_comb begin
    case (mode)
      SENSE_ANY:  edge_hit = pin_s ^ prev_q;
      SENSE_FALL: edge_hit = prev_q & ~pin_s;
      SENSE_RISE: edge_hit = ~prev_q & pin_s;
      default:    edge_hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 1'b1;
      flag   <= 1'b0;
    end else begin
      prev_q <= pin_s;
      if (edge_hit)      flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
    end
  end

  assign level_low = (mode == SENSE_LOW) && !pin_s;
  assign qual      = enabled && level_low;

  always_ff @(posedge clk) begin
    if (rst || !pwr_down) begin
      cnt_q    <= '0;
      wake_hit <= 1'b0;
    end else if (wake_tick) begin
      if (qual) begin
        if (cnt_q >= LAST) wake_hit <= 1'b1;
        else               cnt_q    <= cnt_q + 1'b1;
      end else begin
        cnt_q <= '0;
      end
    end
  end
endmodule

// File: rtl/eic_ctrl.sv
module eic_ctrl
  import eic_pkg::*;
#(
  parameter int NUM_PINS     = 8,
  parameter int SYNC_STAGES  = 2,
  parameter int WAKE_SAMPLES = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic                gie,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [NUM_PINS-1:0] wdata,
  output logic [NUM_PINS-1:0] rdata,
  input  logic                pwr_down,
  input  logic                startup_done,
  input  logic                wake_tick,
  output logic [NUM_PINS-1:0] irq_req,
  output logic                irq_any,
  output logic                wake
);
  logic [NUM_PINS-1:0]   pin_s;
  logic [2*NUM_PINS-1:0] sense;
  logic [NUM_PINS-1:0]   mask_q, flag_clr, flags, level_low, wake_hit, req_d;
  logic                  hold;

  eic_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) i_sync (
    .clk(clk), .rst(rst), .d(pin_in), .q(pin_s)
  );

  eic_regs #(.NUM_PINS(NUM_PINS)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .flags(flags), .sense(sense), .mask(mask_q),
    .flag_clr(flag_clr), .rdata(rdata)
  );

  assign hold = pwr_down && !startup_done;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    sense_e mode;
    assign mode = sense_e'(sense[2*i +: 2]);

    eic_pin #(.WAKE_SAMPLES(WAKE_SAMPLES)) i_pin (
      .clk(clk), .rst(rst), .pin_s(pin_s[i]), .mode(mode),
      .enabled(gie && mask_q[i]), .flag_clr(flag_clr[i]),
      .pwr_down(pwr_down), .wake_tick(wake_tick),
      .flag(flags[i]), .level_low(level_low[i]), .wake_hit(wake_hit[i])
    );

    assign req_d[i] = gie && mask_q[i] && !hold &&
                      ((mode == SENSE_LOW) ? level_low[i] : flags[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req <= '0;
      irq_any <= 1'b0;
    end else begin
      irq_req <= req_d;
      irq_any <= |req_d;
    end
  end

  assign wake = |wake_hit;
endmodule

// File: rtl/eic_ctrl_chk.sv
module eic_ctrl_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                clk,
  input logic                rst,
  input logic                gie,
  input logic                pwr_down,
  input logic                startup_done,
  input logic [NUM_PINS-1:0] mask_q,
  input logic [NUM_PINS-1:0] irq_req,
  input logic                irq_any,
  input logic                wake
);
  assert_req_needs_gie_R5: assert property (@(posedge clk) disable iff (rst)
    !gie |=> (irq_req == '0));

  assert_req_needs_mask_R5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((irq_req & ~$past(mask_q)) == '0));

  assert_startup_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (pwr_down && !startup_done) |=> (irq_req == '0));

  assert_wake_release_R8: assert property (@(posedge clk) disable iff (rst)
    !pwr_down |=> !wake);

  assert_any_matches_R11: assert property (@(posedge clk) disable iff (rst)
    irq_any == (|irq_req));
endmodule

bind eic_ctrl eic_ctrl_chk #(.NUM_PINS(NUM_PINS)) i_chk (
  .clk(clk), .rst(rst), .gie(gie), .pwr_down(pwr_down),
  .startup_done(startup_done), .mask_q(mask_q), .irq_req(irq_req),
  .irq_any(irq_any), .wake(wake)
);

// File: tb/test_eic_ctrl.sv
module test_eic_ctrl;
  localparam int K_RDATA = 0;
  localparam int K_REQ   = 1;
  localparam int K_WAKE  = 2;
  localparam int K_ANY   = 3;

  typedef struct {
    string      tag;
    int         kind;
    logic [7:0] exp;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pin_in = 8'hFF;
  logic       gie = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       pwr_down = 1'b0, startup_done = 1'b0, wake_tick = 1'b0;
  logic [7:0] irq_req;
  logic       irq_any, wake;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail   = 0;
  bit    done     = 1'b0;

  always #5 clk = ~clk;

  eic_ctrl i_eic_ctrl (
    .clk(clk), .rst(rst), .pin_in(pin_in), .gie(gie), .wr_en(wr_en),
    .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .pwr_down(pwr_down), .startup_done(startup_done), .wake_tick(wake_tick),
    .irq_req(irq_req), .irq_any(irq_any), .wake(wake)
  );

  // Monitor: pops expected items and compares them against the ports.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0) begin
        item_t it;
        logic [7:0] act;
        it = q.pop_front();
        case (it.kind)
          K_RDATA: act = rdata;
          K_REQ:   act = irq_req;
          K_WAKE:  act = {7'd0, wake};
          default: act = {7'd0, irq_any};
        endcase
        n_checks++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic push(input string tag, input int kind, input logic [7:0] exp);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = exp;
    q.push_back(it);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_expect(input string tag, input logic [1:0] a, input logic [7:0] exp);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    push(tag, K_RDATA, exp);
    settle(1);
  endtask

  task automatic out_expect(input string tag, input int kind, input logic [7:0] exp);
    push(tag, kind, exp);
    settle(1);
  endtask

  task automatic tick();
    @(negedge clk);
    wake_tick = 1'b1;
    @(negedge clk);
    wake_tick = 1'b0;
  endtask

  initial begin
    settle(4);
    rst = 1'b0;
    settle(2);
    out_expect("R1 reset irq_req", K_REQ, 8'h00);
    out_expect("R1 reset wake", K_WAKE, 8'h00);
    out_expect("R1 reset irq_any", K_ANY, 8'h00);
    rd_expect("R1 reset sense lo", 2'd0, 8'h00);
    rd_expect("R1 reset sense hi", 2'd1, 8'h00);
    rd_expect("R1 reset mask", 2'd2, 8'h00);
    rd_expect("R1 reset flags", 2'd3, 8'h00);

    // Level mode on pin 0
    gie = 1'b1;
    wr(2'd2, 8'h01);
    rd_expect("R2 mask readback", 2'd2, 8'h01);
    pin_in[0] = 1'b0; settle(4);
    out_expect("R4 level low request", K_REQ, 8'h01);
    out_expect("R11 any follows request", K_ANY, 8'h01);
    rd_expect("R4 level leaves no flag", 2'd3, 8'h00);
    pin_in[0] = 1'b1; settle(4);
    out_expect("R4 level released", K_REQ, 8'h00);
    out_expect("R11 any clear", K_ANY, 8'h00);

    // Masking and global enable
    pin_in[1] = 1'b0; settle(4);
    out_expect("R5 masked pin gives no request", K_REQ, 8'h00);
    gie = 1'b0; pin_in[0] = 1'b0; settle(4);
    out_expect("R5 gie low blocks request", K_REQ, 8'h00);
    gie = 1'b1; settle(3);
    out_expect("R5 gie restored", K_REQ, 8'h01);
    pin_in[0] = 1'b1; pin_in[1] = 1'b1; settle(4);

    // Sense fields: pins 2,3 falling; pin 5 rising; pin 6 any change
    wr(2'd0, 8'hA0);
    rd_expect("R2 sense lo readback", 2'd0, 8'hA0);
    wr(2'd1, 8'h1C);
    rd_expect("R2 sense hi readback", 2'd1, 8'h1C);
    settle(3);
    rd_expect("R3 no spurious flags", 2'd3, 8'h00);

    // Flag set while masked
    pin_in[3] = 1'b0; settle(4);
    rd_expect("R7 flag set while masked", 2'd3, 8'h08);
    out_expect("R7 no request while masked", K_REQ, 8'h00);
    wr(2'd2, 8'h09); settle(2);
    out_expect("R7 request after unmask", K_REQ, 8'h08);
    pin_in[3] = 1'b1; settle(4);

    // Write-one-to-clear
    wr(2'd3, 8'h00);
    rd_expect("R6 zero write keeps flag", 2'd3, 8'h08);
    wr(2'd3, 8'h08);
    rd_expect("R6 one write clears flag", 2'd3, 8'h00);
    out_expect("R6 request drops after clear", K_REQ, 8'h00);

    // Falling on pin 2
    wr(2'd2, 8'h65);
    pin_in[2] = 1'b0; settle(4);
    out_expect("R3 falling edge request", K_REQ, 8'h04);
    pin_in[2] = 1'b1; settle(4);
    rd_expect("R3 rising ignored in falling mode", 2'd3, 8'h04);
    wr(2'd3, 8'h04); settle(1);

    // Rising on pin 5
    pin_in[5] = 1'b0; settle(4);
    rd_expect("R3 falling ignored in rising mode", 2'd3, 8'h00);
    pin_in[5] = 1'b1; settle(4);
    rd_expect("R3 rising edge flag", 2'd3, 8'h20);
    out_expect("R3 rising edge request", K_REQ, 8'h20);
    wr(2'd3, 8'h20); settle(1);

    // Any change on pin 6
    pin_in[6] = 1'b0; settle(4);
    rd_expect("R3 any change on fall", 2'd3, 8'h40);
    wr(2'd3, 8'h40);
    pin_in[6] = 1'b1; settle(4);
    rd_expect("R3 any change on rise", 2'd3, 8'h40);
    wr(2'd3, 8'h40); settle(2);
    out_expect("R6 all clear", K_REQ, 8'h00);

    // Wake with level gone before start-up ends
    wr(2'd2, 8'h10);
    pwr_down = 1'b1; startup_done = 1'b0;
    pin_in[4] = 1'b0; settle(4);
    out_expect("R10 requests held during start-up", K_REQ, 8'h00);
    tick(); settle(1);
    out_expect("R8 one sample no wake", K_WAKE, 8'h00);
    tick(); settle(1);
    out_expect("R8 two samples wake", K_WAKE, 8'h01);
    pin_in[4] = 1'b1; settle(4);
    startup_done = 1'b1; settle(3);
    out_expect("R10 wake without request", K_REQ, 8'h00);
    out_expect("R10 wake stays set", K_WAKE, 8'h01);
    pwr_down = 1'b0; settle(2);
    out_expect("R8 wake cleared after power-down", K_WAKE, 8'h00);

    // Non-consecutive samples, then level held through start-up
    pwr_down = 1'b1; startup_done = 1'b0;
    pin_in[4] = 1'b0; settle(4);
    tick();
    pin_in[4] = 1'b1; settle(4);
    tick();
    pin_in[4] = 1'b0; settle(4);
    tick(); settle(1);
    out_expect("R9 broken samples no wake", K_WAKE, 8'h00);
    tick(); settle(1);
    out_expect("R9 consecutive samples wake", K_WAKE, 8'h01);
    startup_done = 1'b1; settle(3);
    out_expect("R10 held level requests after start-up", K_REQ, 8'h10);
    pwr_down = 1'b0; pin_in[4] = 1'b1; settle(4);
    out_expect("R4 request ends with level", K_REQ, 8'h00);

    settle(3);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule